// File: doc/BRIEF.md
# 8-bit ALU with Per-Operation Flag Masks

This block is the arithmetic and logic datapath of a small register-file processor. On each cycle it takes an operation code, a destination operand, a source operand (a register value or an immediate), a 16-bit register-pair value and a 6-bit word immediate. From these it forms an 8-bit result, a 16-bit result and the next value of the status register. The results and the next status value are combinational. The status register itself is held inside the block. It loads the next value on every clock edge where `op_valid` is high.

Each operation owns a fixed set of flags that it may update. Every flag outside that set keeps its current value, so a carry made by an add survives later logic, increment and decrement operations. The sign flag is always recomputed as the XOR of the new negative and overflow flags, even when neither of them changed. Two word operations add a small immediate to a 16-bit register pair, or subtract one from it, and take their flags from the full 16-bit result.

Top module: `alu8_flags`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Bits 7:6 are never changed by any operation. A synchronous active-low reset clears the whole status register to 0x00.
- R2: After every update, status bit S equals N XOR V of the new status value. This holds for operations that leave N and V unchanged.
- R3: ADD (code 0) gives Rd+Rr and ADC (code 1) gives Rd+Rr+C. Both update H, V, N, Z and C. C is the carry out of bit 7, H is the carry out of bit 3 and V is the two's-complement overflow.
- R4: SUB (2) and SUBI (3) give Rd−Rr. SBC (4) and SBCI (5) give Rd−Rr−C. All four update H, V, N, Z and C, with C the borrow out of bit 7 and H the borrow out of bit 3.
- R5: NEG (12) gives 0x00−Rd and updates H, V, N, Z and C as a subtraction from zero.
- R6: AND/ANDI (6/7) give Rd&Rr. OR/ORI/SBR (8/9/13) give Rd|Rr. EOR (10) gives Rd^Rr. CBR (14) gives Rd&~Rr. TST (17) gives Rd. These update Z and N, force V to 0, and keep C and H.
- R7: COM (11) gives 0xFF−Rd, forces C to 1 and V to 0, updates Z and N, and keeps H.
- R8: INC (15) and DEC (16) give Rd+1 and Rd−1. They update Z, N and V and keep C and H.
- R9: ADIW (18) and SBIW (19) give pair+K and pair−K, with the 6-bit K zero-extended. Z comes from all 16 bits and N from bit 15. C is the carry or borrow out of bit 15 and V is the 16-bit overflow. H is kept, and `result8` is the low byte.
- R10: The status register loads only on cycles with `op_valid` high. Codes 20–31 return Rd and leave every flag unchanged. For non-word codes, `result16` is `result8` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Load the status register with the next status value at this edge |
| op_code | input | 5 | Operation code (see requirements) |
| rd_val | input | 8 | Destination operand |
| rr_val | input | 8 | Source register or 8-bit immediate |
| pair_val | input | 16 | Register-pair value (high:low) for word operations |
| word_k | input | 6 | Word immediate, 0 to 63 |
| result8 | output | 8 | 8-bit result |
| result16 | output | 16 | 16-bit result |
| sreg_next | output | 8 | Status value the current operation would produce |
| sreg | output | 8 | Registered status |

## Verification
The bench goes after the sign-overflow boundaries. These are 0x7F+1, 0x80−1, NEG of 0x80, INC of 0x7F and DEC of 0x80, and a design with a wrong V rule gives the wrong V and S at exactly these points. It also checks the nibble carry and borrow with carry-in set, where an H taken from the wrong bit or blind to the carry-in shows up. Carry retention is tested by following an add that sets C with logic, increment and decrement operations, which a wrong flag mask would clear. The word edges 0xFFFF+1, 0x0000−1, 0x7FFF+1 and 0x8000−1 expose a Z or N taken from 8 bits instead of 16, and a wrong bit-15 carry.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the ALU: status bit positions, operation codes,
// logic-unit functions and the per-operation flag update masks.
// Assumes an 8-bit status register; bits 7:6 are not owned by the ALU.
package alu8_pkg;

    localparam int SRW    = 8;
    localparam int OPW    = 5;
    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;

    localparam logic [OPW-1:0] OP_ADD  = 5'd0;
    localparam logic [OPW-1:0] OP_ADC  = 5'd1;
    localparam logic [OPW-1:0] OP_SUB  = 5'd2;
    localparam logic [OPW-1:0] OP_SUBI = 5'd3;
    localparam logic [OPW-1:0] OP_SBC  = 5'd4;
    localparam logic [OPW-1:0] OP_SBCI = 5'd5;
    localparam logic [OPW-1:0] OP_AND  = 5'd6;
    localparam logic [OPW-1:0] OP_ANDI = 5'd7;
    localparam logic [OPW-1:0] OP_OR   = 5'd8;
    localparam logic [OPW-1:0] OP_ORI  = 5'd9;
    localparam logic [OPW-1:0] OP_EOR  = 5'd10;
    localparam logic [OPW-1:0] OP_COM  = 5'd11;
    localparam logic [OPW-1:0] OP_NEG  = 5'd12;
    localparam logic [OPW-1:0] OP_SBR  = 5'd13;
    localparam logic [OPW-1:0] OP_CBR  = 5'd14;
    localparam logic [OPW-1:0] OP_INC  = 5'd15;
    localparam logic [OPW-1:0] OP_DEC  = 5'd16;
    localparam logic [OPW-1:0] OP_TST  = 5'd17;
    localparam logic [OPW-1:0] OP_ADIW = 5'd18;
    localparam logic [OPW-1:0] OP_SBIW = 5'd19;

    // Update masks: a 1 means the operation may write that status bit.
    localparam logic [SRW-1:0] M_ARITH  = 8'b0010_1111;  // H V N Z C
    localparam logic [SRW-1:0] M_ZNV    = 8'b0000_1110;  // V N Z
    localparam logic [SRW-1:0] M_VNZC   = 8'b0000_1111;  // V N Z C
    localparam logic [SRW-1:0] M_NONE   = 8'b0000_0000;

    typedef enum logic [2:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOT,
        LG_CLR
    } logic_fn_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ARITH,
        SEL_LOGIC,
        SEL_WORD
    } unit_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// Width-parameterised adder/subtractor with carry-in.
// Produces the result, the carry (or borrow when sub=1) out of the top bit,
// the carry/borrow out of the lower half, and the two's-complement overflow.
// Assumes W is even; subtraction is a - b - cin.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HW = W / 2;

    logic [W-1:0] b_eff;
    logic         cin_eff;
    logic [W:0]   sum;
    logic [HW:0]  nib;

    // Fold subtraction into addition of the inverted operand.
    always_comb begin : fold_sub
        b_eff   = sub ? ~b : b;
        cin_eff = sub ? ~cin : cin;
    end

    // Full-width and lower-half sums; borrow is the inverted carry.
    always_comb begin : sums
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
        nib   = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin_eff};
        r     = sum[W-1:0];
        c_out = sub ? ~sum[W] : sum[W];
        h_out = sub ? ~nib[HW] : nib[HW];
        v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
// Bitwise logic unit: AND, OR, XOR, NOT of a, and AND with inverted b.
// Purely combinational; flags are formed by the caller.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic_fn_e    fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    // Select the bitwise function.
    always_comb begin : logic_sel
        case (fn)
            LG_AND:  r = a & b;
            LG_OR:   r = a | b;
            LG_XOR:  r = a ^ b;
            LG_NOT:  r = ~a;
            LG_CLR:  r = a & ~b;
            default: r = a;
        endcase
    end

endmodule

// File: rtl/alu8_word.sv
`timescale 1ns/1ps
// Register-pair add/subtract of a small zero-extended immediate.
// Gives the WW-bit result, the carry/borrow out of the top bit and the
// overflow. Assumes KW < WW.
module alu8_word #(
    parameter int WW = 16,
    parameter int KW = 6
) (
    input  logic [WW-1:0] pair,
    input  logic [KW-1:0] k,
    input  logic          sub,
    output logic [WW-1:0] r,
    output logic          c_out,
    output logic          v_out
);
    logic [WW-1:0] kz;
    logic [WW:0]   full;

    // Extended add or subtract; the top bit is the carry or borrow.
    always_comb begin : pair_math
        kz    = {{(WW-KW){1'b0}}, k};
        full  = sub ? ({1'b0, pair} - {1'b0, kz}) : ({1'b0, pair} + {1'b0, kz});
        r     = full[WW-1:0];
        c_out = full[WW];
        v_out = sub ? (pair[WW-1] & ~full[WW-1]) : (~pair[WW-1] & full[WW-1]);
    end

endmodule

// File: rtl/alu8_flagmerge.sv
`timescale 1ns/1ps
// Merges candidate flags into the current status under an update mask,
// then recomputes the sign bit from the merged N and V.
module alu8_flagmerge
    import alu8_pkg::*;
(
    input  logic [SRW-1:0] cur,
    input  logic [SRW-1:0] cand,
    input  logic [SRW-1:0] mask,
    output logic [SRW-1:0] nxt
);
    logic [SRW-1:0] merged;

    // Keep unmasked bits, take masked bits from the candidate, derive S.
    always_comb begin : merge
        merged         = (cur & ~mask) | (cand & mask);
        nxt            = merged;
        nxt[FLAG_S]    = merged[FLAG_N] ^ merged[FLAG_V];
    end

endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
// ALU top: decodes the operation code, steers operands to the add/sub,
// logic and word units, selects the result, and forms the next status
// value under the operation's flag mask. The status register loads the
// next value on clock edges where op_valid is high.
// Assumes operands are stable for the cycle in which op_valid is high.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW = 8,
    parameter int WW = 16,
    parameter int KW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  rd_val,
    input  logic [DW-1:0]  rr_val,
    input  logic [WW-1:0]  pair_val,
    input  logic [KW-1:0]  word_k,
    output logic [DW-1:0]  result8,
    output logic [WW-1:0]  result16,
    output logic [SRW-1:0] sreg_next,
    output logic [SRW-1:0] sreg
);
    logic [SRW-1:0] sreg_q;
    logic [SRW-1:0] upd_mask;
    logic [SRW-1:0] cand;
    unit_sel_e      sel;
    logic_fn_e      lfn;
    logic [DW-1:0]  add_a, add_b, add_r, log_b, log_r;
    logic           add_cin, add_sub, add_c, add_h, add_v;
    logic           com_op, word_sub, word_c, word_v;
    logic [WW-1:0]  word_r;
    logic [DW-1:0]  res8;

    // Steer operands to the units and pick the flag mask for the code.
    always_comb begin : decode_ops
        add_a    = rd_val;
        add_b    = rr_val;
        add_cin  = 1'b0;
        add_sub  = 1'b0;
        log_b    = rr_val;
        lfn      = LG_AND;
        com_op   = 1'b0;
        word_sub = 1'b0;
        sel      = SEL_NONE;
        upd_mask = M_NONE;
        case (op_code)
            OP_ADD: begin
                sel = SEL_ARITH; upd_mask = M_ARITH;
            end
            OP_ADC: begin
                sel = SEL_ARITH; upd_mask = M_ARITH; add_cin = sreg_q[FLAG_C];
            end
            OP_SUB, OP_SUBI: begin
                sel = SEL_ARITH; upd_mask = M_ARITH; add_sub = 1'b1;
            end
            OP_SBC, OP_SBCI: begin
                sel = SEL_ARITH; upd_mask = M_ARITH; add_sub = 1'b1;
                add_cin = sreg_q[FLAG_C];
            end
            OP_NEG: begin
                sel = SEL_ARITH; upd_mask = M_ARITH; add_sub = 1'b1;
                add_a = '0; add_b = rd_val;
            end
            OP_INC: begin
                sel = SEL_ARITH; upd_mask = M_ZNV; add_b = DW'(1);
            end
            OP_DEC: begin
                sel = SEL_ARITH; upd_mask = M_ZNV; add_b = DW'(1); add_sub = 1'b1;
            end
            OP_AND, OP_ANDI: begin
                sel = SEL_LOGIC; upd_mask = M_ZNV; lfn = LG_AND;
            end
            OP_OR, OP_ORI, OP_SBR: begin
                sel = SEL_LOGIC; upd_mask = M_ZNV; lfn = LG_OR;
            end
            OP_EOR: begin
                sel = SEL_LOGIC; upd_mask = M_ZNV; lfn = LG_XOR;
            end
            OP_CBR: begin
                sel = SEL_LOGIC; upd_mask = M_ZNV; lfn = LG_CLR;
            end
            OP_TST: begin
                sel = SEL_LOGIC; upd_mask = M_ZNV; lfn = LG_AND; log_b = rd_val;
            end
            OP_COM: begin
                sel = SEL_LOGIC; upd_mask = M_VNZC; lfn = LG_NOT; com_op = 1'b1;
            end
            OP_ADIW: begin
                sel = SEL_WORD; upd_mask = M_VNZC;
            end
            OP_SBIW: begin
                sel = SEL_WORD; upd_mask = M_VNZC; word_sub = 1'b1;
            end
            default: begin
                sel = SEL_NONE; upd_mask = M_NONE;
            end
        endcase
    end

    alu8_addsub #(.W(DW)) addsub_i (
        .a(add_a), .b(add_b), .cin(add_cin), .sub(add_sub),
        .r(add_r), .c_out(add_c), .h_out(add_h), .v_out(add_v)
    );

    alu8_logic #(.W(DW)) logic_i (
        .fn(lfn), .a(rd_val), .b(log_b), .r(log_r)
    );

    alu8_word #(.WW(WW), .KW(KW)) word_i (
        .pair(pair_val), .k(word_k), .sub(word_sub),
        .r(word_r), .c_out(word_c), .v_out(word_v)
    );

    // Select the result and build the candidate flags from the active unit.
    always_comb begin : result_sel
        cand = '0;
        case (sel)
            SEL_ARITH: begin
                res8         = add_r;
                cand[FLAG_C] = add_c;
                cand[FLAG_H] = add_h;
                cand[FLAG_V] = add_v;
                cand[FLAG_N] = add_r[DW-1];
                cand[FLAG_Z] = (add_r == '0);
            end
            SEL_LOGIC: begin
                res8         = log_r;
                cand[FLAG_C] = com_op;
                cand[FLAG_N] = log_r[DW-1];
                cand[FLAG_Z] = (log_r == '0);
            end
            SEL_WORD: begin
                res8         = word_r[DW-1:0];
                cand[FLAG_C] = word_c;
                cand[FLAG_V] = word_v;
                cand[FLAG_N] = word_r[WW-1];
                cand[FLAG_Z] = (word_r == '0);
            end
            default: res8 = rd_val;
        endcase
        result16 = (sel == SEL_WORD) ? word_r : {{(WW-DW){1'b0}}, res8};
    end

    assign result8 = res8;

    alu8_flagmerge merge_i (
        .cur(sreg_q), .cand(cand), .mask(upd_mask), .nxt(sreg_next)
    );

    // Status register: cleared by reset, loaded on valid operations.
    always_ff @(posedge clk) begin : status_reg
        if (!rst_n)        sreg_q <= '0;
        else if (op_valid) sreg_q <= sreg_next;
    end

    assign sreg = sreg_q;

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sreg_q[7:6] == 2'b00); // R1
    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n) sreg_q[FLAG_S] == (sreg_q[FLAG_N] ^ sreg_q[FLAG_V])); // R2
    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && sel == SEL_LOGIC && !com_op) |=> (sreg_q[FLAG_C] == $past(sreg_q[FLAG_C]) && !sreg_q[FLAG_V])); // R6
    AST_COM_FORCE: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_COM) |=> (sreg_q[FLAG_C] && !sreg_q[FLAG_V])); // R7
    AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> (sreg_q[FLAG_C] == $past(sreg_q[FLAG_C]) && sreg_q[FLAG_H] == $past(sreg_q[FLAG_H]))); // R8
    AST_WORD_KEEPS_HALF: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && sel == SEL_WORD) |=> (sreg_q[FLAG_H] == $past(sreg_q[FLAG_H]))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> $stable(sreg_q)); // R10

endmodule

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [7:0]  rd_val = '0, rr_val = '0;
    logic [15:0] pair_val = '0;
    logic [5:0]  word_k = '0;
    logic [7:0]  result8, sreg_next, sreg;
    logic [15:0] result16;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [7:0] model_s = 8'h00;

    always #10 clk = ~clk;

    alu8_flags dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .rd_val(rd_val), .rr_val(rr_val), .pair_val(pair_val), .word_k(word_k),
        .result8(result8), .result16(result16), .sreg_next(sreg_next), .sreg(sreg)
    );

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:                         return "R3";
            5'd2, 5'd3, 5'd4, 5'd5:             return "R4";
            5'd12:                              return "R5";
            5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
            5'd13, 5'd14, 5'd17:                return "R6";
            5'd11:                              return "R7";
            5'd15, 5'd16:                       return "R8";
            5'd18, 5'd19:                       return "R9";
            default:                            return "R10";
        endcase
    endfunction

    function automatic int sx8(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // Reference model written from the requirements.
    task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] p, input logic [5:0] k, input logic [7:0] s,
                         output logic [7:0] r8, output logic [15:0] r16, output logic [7:0] ns);
        int x, y, ci, full, sr;
        bit c, z, n, v, h, is_add, is_sub, is_word;
        logic [7:0] mask, cand, r;
        c = 0; z = 0; n = 0; v = 0; h = 0; mask = 8'h00;
        x = a; y = b; ci = 0; r = a;
        is_add = (op == 0 || op == 1 || op == 15);
        is_sub = (op inside {5'd2, 5'd3, 5'd4, 5'd5, 5'd12, 5'd16});
        is_word = (op == 18 || op == 19);
        if (op == 1 || op == 4 || op == 5) ci = s[0];
        if (op == 15 || op == 16) y = 1;
        if (op == 12) begin x = 0; y = a; end
        if (is_add) begin
            full = x + y + ci; r = full[7:0]; c = full > 255;
            h = ((x % 16) + (y % 16) + ci) > 15;
            sr = sx8(x) + sx8(y) + ci; v = (sr > 127) || (sr < -128);
            mask = (op == 15) ? 8'h0E : 8'h2F;
        end else if (is_sub) begin
            full = x - y - ci; r = full[7:0]; c = full < 0;
            h = ((x % 16) - (y % 16) - ci) < 0;
            sr = sx8(x) - sx8(y) - ci; v = (sr > 127) || (sr < -128);
            mask = (op == 16) ? 8'h0E : 8'h2F;
        end else if (is_word) begin
            full = (op == 18) ? int'(p) + int'(k) : int'(p) - int'(k);
            c = (full > 65535) || (full < 0);
            sr = ((p > 16'h7FFF) ? int'(p) - 65536 : int'(p)) + ((op == 18) ? int'(k) : -int'(k));
            v = (sr > 32767) || (sr < -32768);
            mask = 8'h0F;
        end else begin
            mask = 8'h0E;
            case (op)
                5'd6, 5'd7:        r = a & b;
                5'd8, 5'd9, 5'd13: r = a | b;
                5'd10:             r = a ^ b;
                5'd14:             r = a & ~b;
                5'd17:             r = a;
                5'd11: begin r = ~a; c = 1; mask = 8'h0F; end
                default: begin r = a; mask = 8'h00; end
            endcase
        end
        if (is_word) begin
            r16 = full[15:0]; r8 = r16[7:0]; n = r16[15]; z = (r16 == 16'h0);
        end else begin
            r8 = r; r16 = {8'h00, r}; n = r[7]; z = (r == 8'h00);
        end
        cand = {2'b00, h, 1'b0, v, n, z, c};
        ns = (s & ~mask) | (cand & mask);
        ns[4] = ns[2] ^ ns[3];
    endtask

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one operation, check combinational outputs, then the register.
    task automatic run_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [15:0] p, input logic [5:0] k);
        logic [7:0] e8, es;
        logic [15:0] e16;
        string rq;
        @(negedge clk);
        op_code = op; rd_val = a; rr_val = b; pair_val = p; word_k = k; op_valid = 1'b1;
        #2;
        rq = req_of(op);
        model(op, a, b, p, k, model_s, e8, e16, es);
        check(rq, "result8", {8'h00, result8}, {8'h00, e8});
        check(rq, "result16", result16, e16);
        check(rq, "sreg_next", {8'h00, sreg_next}, {8'h00, es});
        @(posedge clk);
        #1;
        check(rq, "sreg", {8'h00, sreg}, {8'h00, es});
        check("R2", "S==N^V", {15'h0, sreg[4]}, {15'h0, sreg[2] ^ sreg[3]});
        model_s = es;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset sreg", {8'h00, sreg}, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        // R3 overflow / half carry / carry boundaries
        run_op(5'd0, 8'h7F, 8'h01, 16'h0, 6'h0);
        run_op(5'd0, 8'hFF, 8'h01, 16'h0, 6'h0);
        run_op(5'd1, 8'h0F, 8'h00, 16'h0, 6'h0);   // ADC with C=1 from previous
        // R4 borrows
        run_op(5'd2, 8'h80, 8'h01, 16'h0, 6'h0);
        run_op(5'd3, 8'h00, 8'h01, 16'h0, 6'h0);
        run_op(5'd4, 8'h10, 8'h00, 16'h0, 6'h0);   // SBC with C=1
        run_op(5'd5, 8'h00, 8'h00, 16'h0, 6'h0);
        // R5 negate corners
        run_op(5'd12, 8'h80, 8'h00, 16'h0, 6'h0);
        run_op(5'd12, 8'h00, 8'h00, 16'h0, 6'h0);
        // Carry retention across logic, R6 and R8
        run_op(5'd0, 8'hFF, 8'h02, 16'h0, 6'h0);
        run_op(5'd6, 8'hF0, 8'h0F, 16'h0, 6'h0);
        run_op(5'd15, 8'h7F, 8'h00, 16'h0, 6'h0);
        run_op(5'd16, 8'h80, 8'h00, 16'h0, 6'h0);
        run_op(5'd15, 8'hFF, 8'h00, 16'h0, 6'h0);
        run_op(5'd17, 8'h80, 8'h00, 16'h0, 6'h0);
        run_op(5'd14, 8'hFF, 8'h0F, 16'h0, 6'h0);
        // R7 complement
        run_op(5'd11, 8'hFF, 8'h00, 16'h0, 6'h0);
        // R9 word corners
        run_op(5'd18, 8'h00, 8'h00, 16'hFFFF, 6'd1);
        run_op(5'd19, 8'h00, 8'h00, 16'h0000, 6'd1);
        run_op(5'd18, 8'h00, 8'h00, 16'h7FFF, 6'd1);
        run_op(5'd19, 8'h00, 8'h00, 16'h8000, 6'd1);
        run_op(5'd18, 8'h00, 8'h00, 16'h00C5, 6'd63);
        // R10 unused code keeps flags
        run_op(5'd0, 8'hFF, 8'h01, 16'h0, 6'h0);
        run_op(5'd25, 8'h3C, 8'h00, 16'h0, 6'h0);
        // R10 idle cycle holds status
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'd11; rd_val = 8'h00;
        held = model_s;
        @(posedge clk); #1;
        check("R10", "idle sreg", {8'h00, sreg}, {8'h00, held});

        for (int i = 0; i < 4000; i++) begin
            logic [4:0] op;
            op = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 20);
            run_op(op, 8'($urandom), 8'($urandom), 16'($urandom), 6'($urandom));
        end

        @(negedge clk); op_valid = 1'b0;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule